// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects 64 level-sensitive interrupt lines and presents them to a processor as two requests: a normal interrupt and a fast interrupt. Software controls it through a small 32-bit register bus. Through that bus it can enable each line, either one bit at a time in a 64-bit mask or by writing a line number. It can choose for each line which of the two requests the line feeds, raise any line from software, and give each line a 4-bit priority.

Every 64-bit quantity is split across two words. Lines 0 to 31 sit in the low word and lines 32 to 63 in the high word. Two vector words report the winning line so that a handler can loop: read the normal vector, service the line it names, and stop when the vector reads all-ones. Normal requests are ranked by priority and filtered by a programmable threshold. Fast requests are ranked only by line number. Both request outputs are registered.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset the control word reads 0, the normal threshold reads 0x1F, and all enable, route, force and priority bits read 0. Both vector words read 0xFFFF0000.
- R2: Enable (0x10 high, 0x14 low), route (0x18 high, 0x1C low) and force (0x50 high, 0x54 low) are read/write. Bit k of a low word belongs to line k. Bit k of a high word belongs to line 32+k.
- R3: Writing a value below 64 to 0x08 sets that line's enable bit. Writing such a value to 0x0C clears it. A value of 64 or more written to either address changes nothing. Both addresses read 0.
- R4: 0x48/0x4C read the live input lines. 0x58/0x5C read normal pending = (input | force) & enable & ~route. 0x60/0x64 read fast pending = (input | force) & enable & route. A route bit of 1 selects the fast request.
- R5: The eight priority words live at 0x20 + 4*(7-x), so word 7 is at 0x20 and word 0 is at 0x3C. Line n takes its priority from bits [4*(n%8)+3 : 4*(n%8)] of word n/8.
- R6: The normal vector word at 0x40 holds in bits [31:16] the number of the pending normal line with the highest priority. Among equal priorities the higher line number wins. The field reads 0xFFFF when no line qualifies. Bits [15:0] read 0.
- R7: The threshold at 0x04 is 5 bits wide. When its bit 4 is set, every normal line qualifies. Otherwise a normal line qualifies only if its priority is strictly greater than threshold bits [3:0].
- R8: The fast vector word at 0x44 holds in bits [31:16] the highest-numbered fast pending line, or 0xFFFF when there is none. Bits [15:0] read 0.
- R9: irq_norm_o and irq_fast_o are high in the cycle after the clock edge at which the matching vector field was not 0xFFFF. They are low at and right after reset.
- R10: Writes to the input, pending and vector words leave all state unchanged. Addresses with bits [1:0] not zero, and unmapped addresses, read 0 and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_src | input | 64 | Level-sensitive interrupt lines |
| irq_norm_o | output | 1 | Registered normal interrupt request |
| irq_fast_o | output | 1 | Registered fast interrupt request |

## Verification
The ranking is exercised with lines that differ in priority, lines that tie at one priority (the higher number must win), and no qualifying line (all-ones). Each pattern separates a correct priority comparator from one that only scans line numbers. Threshold values just below, at and above a winner's priority, plus the bypass value with bit 4 set, separate strict from non-strict comparison. Mixed route patterns with the same inputs show that a line feeds exactly one request. A long stretch of random inputs, priorities, thresholds and enables, checked against a behavioural model on every cycle, covers the one-cycle output latency and the out-of-range line numbers.

// File: rtl/irq_vec_pkg.sv
`timescale 1ns/1ps
package irq_vec_pkg;
  localparam int IV_NSRC = 64;
  localparam int IV_DW   = 32;
  localparam int IV_PW   = 4;
  localparam int IV_MW   = 5;
  localparam int IV_VW   = 16;

  // word indices (byte offset / 4)
  localparam logic [5:0] W_CTRL   = 6'd0;
  localparam logic [5:0] W_THR    = 6'd1;
  localparam logic [5:0] W_ENNUM  = 6'd2;
  localparam logic [5:0] W_DISNUM = 6'd3;
  localparam logic [5:0] W_ENH    = 6'd4;
  localparam logic [5:0] W_ENL    = 6'd5;
  localparam logic [5:0] W_RTH    = 6'd6;
  localparam logic [5:0] W_RTL    = 6'd7;
  localparam logic [5:0] W_PRI7   = 6'd8;   // lowest address holds word 7
  localparam logic [5:0] W_PRI0   = 6'd15;
  localparam logic [5:0] W_NVEC   = 6'd16;
  localparam logic [5:0] W_FVEC   = 6'd17;
  localparam logic [5:0] W_SRCH   = 6'd18;
  localparam logic [5:0] W_SRCL   = 6'd19;
  localparam logic [5:0] W_FRCH   = 6'd20;
  localparam logic [5:0] W_FRCL   = 6'd21;
  localparam logic [5:0] W_NPH    = 6'd22;
  localparam logic [5:0] W_NPL    = 6'd23;
  localparam logic [5:0] W_FPH    = 6'd24;
  localparam logic [5:0] W_FPL    = 6'd25;

  localparam logic [IV_MW-1:0] THR_RESET = 5'h1F;

  // pending for one request class: route_fast selects which class
  function automatic logic [IV_NSRC-1:0] route_pend(
    input logic [IV_NSRC-1:0] lines,
    input logic [IV_NSRC-1:0] frc,
    input logic [IV_NSRC-1:0] en,
    input logic [IV_NSRC-1:0] rt,
    input logic               route_fast);
    logic [IV_NSRC-1:0] sel;
    sel = route_fast ? rt : ~rt;
    return (lines | frc) & en & sel;
  endfunction
endpackage

// File: rtl/irq_vec_regs.sv
`timescale 1ns/1ps
module irq_vec_regs
  import irq_vec_pkg::*;
#(
  parameter int NSRC = IV_NSRC,
  parameter int DW   = IV_DW,
  parameter int PW   = IV_PW,
  parameter int MW   = IV_MW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [5:0]         wr_word,
  input  logic [DW-1:0]      wr_data,
  output logic [NSRC-1:0]    en_q,
  output logic [NSRC-1:0]    rt_q,
  output logic [NSRC-1:0]    frc_q,
  output logic [NSRC*PW-1:0] pri_q,
  output logic [MW-1:0]      thr_q,
  output logic [DW-1:0]      ctrl_q
);
  localparam int HALF = NSRC / 2;
  localparam int NPR  = NSRC * PW / DW;
  localparam int IW   = $clog2(NSRC);

  // named events for the checks below
  logic          num_ok;
  logic          ennum_hit;
  logic          disnum_hit;
  logic          ro_hit;
  logic [IW-1:0] num_idx;

  assign num_ok     = (wr_data < DW'(NSRC));
  assign num_idx    = wr_data[IW-1:0];
  assign ennum_hit  = wr_en && (wr_word == W_ENNUM);
  assign disnum_hit = wr_en && (wr_word == W_DISNUM);
  assign ro_hit     = wr_en && (wr_word inside {W_NVEC, W_FVEC, W_SRCH, W_SRCL,
                                                W_NPH, W_NPL, W_FPH, W_FPL});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      rt_q   <= '0;
      frc_q  <= '0;
      pri_q  <= '0;
      thr_q  <= THR_RESET;
      ctrl_q <= '0;
    end else if (wr_en) begin
      case (wr_word)
        W_CTRL:   ctrl_q <= wr_data;
        W_THR:    thr_q  <= wr_data[MW-1:0];
        W_ENNUM:  if (num_ok) en_q[num_idx] <= 1'b1;
        W_DISNUM: if (num_ok) en_q[num_idx] <= 1'b0;
        W_ENH:    en_q[NSRC-1:HALF]  <= wr_data[HALF-1:0];
        W_ENL:    en_q[HALF-1:0]     <= wr_data[HALF-1:0];
        W_RTH:    rt_q[NSRC-1:HALF]  <= wr_data[HALF-1:0];
        W_RTL:    rt_q[HALF-1:0]     <= wr_data[HALF-1:0];
        W_FRCH:   frc_q[NSRC-1:HALF] <= wr_data[HALF-1:0];
        W_FRCL:   frc_q[HALF-1:0]    <= wr_data[HALF-1:0];
        default: begin
          for (int x = 0; x < NPR; x++) begin
            if (wr_word == 6'(int'(W_PRI0) - x)) pri_q[DW*x +: DW] <= wr_data;
          end
        end
      endcase
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (thr_q == THR_RESET && en_q == '0 && rt_q == '0 &&
                      frc_q == '0 && pri_q == '0 && ctrl_q == '0));

  assert_num_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ennum_hit && num_ok) |=> en_q[$past(num_idx)]);

  assert_num_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (disnum_hit && num_ok) |=> !en_q[$past(num_idx)]);

  assert_num_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((ennum_hit || disnum_hit) && !num_ok) |=> $stable(en_q));

  assert_ro_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ro_hit |=> ($stable(en_q) && $stable(rt_q) && $stable(frc_q) &&
                $stable(pri_q) && $stable(thr_q) && $stable(ctrl_q)));
endmodule

// File: rtl/irq_vec_arb.sv
`timescale 1ns/1ps
module irq_vec_arb
  import irq_vec_pkg::*;
#(
  parameter int NSRC = IV_NSRC,
  parameter int PW   = IV_PW,
  parameter int MW   = IV_MW,
  parameter int VW   = IV_VW
) (
  input  logic [NSRC-1:0]    cand,
  input  logic [NSRC*PW-1:0] pri,
  input  logic [MW-1:0]      thr,
  output logic [VW-1:0]      vec,
  output logic               hit
);
  logic [NSRC-1:0] elig;

  // threshold gate per line: bit MW-1 bypasses the compare
  for (genvar g = 0; g < NSRC; g++) begin : g_gate
    assign elig[g] = cand[g] &&
                     (thr[MW-1] || (pri[PW*g +: PW] > thr[PW-1:0]));
  end

  // ascending scan with >= so a later (higher) line wins a tie
  function automatic logic [VW-1:0] pick_ranked(
    input logic [NSRC-1:0]    c,
    input logic [NSRC*PW-1:0] p);
    logic          found;
    logic [PW-1:0] best;
    logic [VW-1:0] r;
    found = 1'b0;
    best  = '0;
    r     = '1;
    for (int i = 0; i < NSRC; i++) begin
      if (c[i] && (!found || p[PW*i +: PW] >= best)) begin
        found = 1'b1;
        best  = p[PW*i +: PW];
        r     = VW'(i);
      end
    end
    return r;
  endfunction

  assign vec = pick_ranked(elig, pri);
  assign hit = (vec != '1);
endmodule

// File: rtl/irq_vec_ctrl.sv
`timescale 1ns/1ps
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NSRC   = IV_NSRC,
  parameter int DW     = IV_DW,
  parameter int PW     = IV_PW,
  parameter int MW     = IV_MW,
  parameter int VW     = IV_VW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NSRC-1:0]   irq_src,
  output logic              irq_norm_o,
  output logic              irq_fast_o
);
  localparam int HALF = NSRC / 2;
  localparam int IW   = $clog2(NSRC);

  logic              aligned;
  logic [5:0]        word;
  logic [NSRC-1:0]   en_q, rt_q, frc_q;
  logic [NSRC*PW-1:0] pri_q;
  logic [MW-1:0]     thr_q;
  logic [DW-1:0]     ctrl_q;
  logic [NSRC-1:0]   npend, fpend;
  logic [VW-1:0]     n_vec, f_vec;
  logic              n_hit, f_hit;

  assign aligned = (bus_addr[1:0] == 2'b00) && (bus_addr[ADDR_W-1:2] < 26);
  assign word    = aligned ? 6'(bus_addr[ADDR_W-1:2]) : 6'h3F;

  irq_vec_regs #(.NSRC(NSRC), .DW(DW), .PW(PW), .MW(MW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_we && aligned),
    .wr_word (word),
    .wr_data (bus_wdata),
    .en_q    (en_q),
    .rt_q    (rt_q),
    .frc_q   (frc_q),
    .pri_q   (pri_q),
    .thr_q   (thr_q),
    .ctrl_q  (ctrl_q)
  );

  assign npend = route_pend(irq_src, frc_q, en_q, rt_q, 1'b0);
  assign fpend = route_pend(irq_src, frc_q, en_q, rt_q, 1'b1);

  irq_vec_arb #(.NSRC(NSRC), .PW(PW), .MW(MW), .VW(VW)) u_arb_norm (
    .cand (npend),
    .pri  (pri_q),
    .thr  (thr_q),
    .vec  (n_vec),
    .hit  (n_hit)
  );

  // fast class: equal ranks and bypassed threshold leave line number as the only key
  irq_vec_arb #(.NSRC(NSRC), .PW(PW), .MW(MW), .VW(VW)) u_arb_fast (
    .cand (fpend),
    .pri  ('0),
    .thr  ({1'b1, {(MW-1){1'b0}}}),
    .vec  (f_vec),
    .hit  (f_hit)
  );

  always_comb begin
    bus_rdata = '0;
    case (word)
      W_CTRL: bus_rdata = ctrl_q;
      W_THR:  bus_rdata = DW'(thr_q);
      W_ENH:  bus_rdata = en_q[NSRC-1:HALF];
      W_ENL:  bus_rdata = en_q[HALF-1:0];
      W_RTH:  bus_rdata = rt_q[NSRC-1:HALF];
      W_RTL:  bus_rdata = rt_q[HALF-1:0];
      W_NVEC: bus_rdata = {n_vec, {(DW-VW){1'b0}}};
      W_FVEC: bus_rdata = {f_vec, {(DW-VW){1'b0}}};
      W_SRCH: bus_rdata = irq_src[NSRC-1:HALF];
      W_SRCL: bus_rdata = irq_src[HALF-1:0];
      W_FRCH: bus_rdata = frc_q[NSRC-1:HALF];
      W_FRCL: bus_rdata = frc_q[HALF-1:0];
      W_NPH:  bus_rdata = npend[NSRC-1:HALF];
      W_NPL:  bus_rdata = npend[HALF-1:0];
      W_FPH:  bus_rdata = fpend[NSRC-1:HALF];
      W_FPL:  bus_rdata = fpend[HALF-1:0];
      default: begin
        for (int x = 0; x < 8; x++) begin
          if (word == 6'(int'(W_PRI0) - x)) bus_rdata = pri_q[DW*x +: DW];
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_norm_o <= 1'b0;
      irq_fast_o <= 1'b0;
    end else begin
      irq_norm_o <= n_hit;
      irq_fast_o <= f_hit;
    end
  end

  assert_norm_win_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    n_hit |-> npend[n_vec[IW-1:0]]);

  assert_fast_win_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    f_hit |-> fpend[f_vec[IW-1:0]]);

  assert_thr_respected_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (n_hit && !thr_q[MW-1]) |-> (pri_q[PW*n_vec[IW-1:0] +: PW] > thr_q[PW-1:0]));

  assert_norm_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    n_hit |=> irq_norm_o);

  assert_fast_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !f_hit |=> !irq_fast_o);
endmodule

// File: tb/irq_vec_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vec_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] src = '0;
  logic        irq_n, irq_f;

  int total = 0;
  int bad   = 0;

  // behavioural model state
  logic [31:0] m_ctrl;
  logic [4:0]  m_thr;
  logic [63:0] m_en, m_rt, m_frc;
  int          m_pri [64];
  logic        exp_n = 1'b0, exp_f = 1'b0;

  always #2.5 clk = ~clk;

  irq_vec_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(rdata), .irq_src(src), .irq_norm_o(irq_n), .irq_fast_o(irq_f));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic void model_reset();
    m_ctrl = '0; m_thr = 5'h1F; m_en = '0; m_rt = '0; m_frc = '0;
    for (int i = 0; i < 64; i++) m_pri[i] = 0;
  endfunction

  function automatic logic [63:0] m_npend();
    return (src | m_frc) & m_en & ~m_rt;
  endfunction
  function automatic logic [63:0] m_fpend();
    return (src | m_frc) & m_en & m_rt;
  endfunction

  // rank from top priority down, then from top line down
  function automatic logic [15:0] m_nvec();
    logic [63:0] p;
    p = m_npend();
    for (int lvl = 15; lvl >= 0; lvl--) begin
      if (m_thr[4] || lvl > int'(m_thr[3:0])) begin
        for (int n = 63; n >= 0; n--) if (p[n] && m_pri[n] == lvl) return 16'(n);
      end
    end
    return 16'hFFFF;
  endfunction

  function automatic logic [15:0] m_fvec();
    logic [63:0] p;
    p = m_fpend();
    for (int n = 63; n >= 0; n--) if (p[n]) return 16'(n);
    return 16'hFFFF;
  endfunction

  function automatic void model_write(input logic [7:0] a, input logic [31:0] d);
    if (a >= 8'h20 && a <= 8'h3C && a[1:0] == 2'b00) begin
      int x;
      x = 7 - (int'(a) - 32) / 4;
      for (int k = 0; k < 8; k++) m_pri[8*x + k] = int'(d[4*k +: 4]);
    end else begin
      case (a)
        8'h00: m_ctrl = d;
        8'h04: m_thr = d[4:0];
        8'h08: if (d < 64) m_en[d[5:0]] = 1'b1;
        8'h0C: if (d < 64) m_en[d[5:0]] = 1'b0;
        8'h10: m_en[63:32] = d;
        8'h14: m_en[31:0] = d;
        8'h18: m_rt[63:32] = d;
        8'h1C: m_rt[31:0] = d;
        8'h50: m_frc[63:32] = d;
        8'h54: m_frc[31:0] = d;
        default: ;
      endcase
    end
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a);
    logic [31:0] r;
    logic [63:0] np, fp;
    np = m_npend(); fp = m_fpend();
    r = '0;
    if (a >= 8'h20 && a <= 8'h3C && a[1:0] == 2'b00) begin
      int x;
      x = 7 - (int'(a) - 32) / 4;
      for (int k = 0; k < 8; k++) r[4*k +: 4] = 4'(m_pri[8*x + k]);
    end else begin
      case (a)
        8'h00: r = m_ctrl;
        8'h04: r = {27'd0, m_thr};
        8'h10: r = m_en[63:32];
        8'h14: r = m_en[31:0];
        8'h18: r = m_rt[63:32];
        8'h1C: r = m_rt[31:0];
        8'h40: r = {m_nvec(), 16'h0};
        8'h44: r = {m_fvec(), 16'h0};
        8'h48: r = src[63:32];
        8'h4C: r = src[31:0];
        8'h50: r = m_frc[63:32];
        8'h54: r = m_frc[31:0];
        8'h58: r = np[63:32];
        8'h5C: r = np[31:0];
        8'h60: r = fp[63:32];
        8'h64: r = fp[31:0];
        default: r = '0;
      endcase
    end
    return r;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    addr = a; we = 1'b1; wdata = d;
    @(posedge clk);
    model_write(a, d);
    #1 we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a);
    @(posedge clk); #1;
    addr = a; we = 1'b0;
    @(negedge clk); #0.5;
    check(tag, rdata, model_read(a));
  endtask

  task automatic rd_lit(input string tag, input logic [7:0] a, input logic [31:0] e);
    @(posedge clk); #1;
    addr = a; we = 1'b0;
    @(negedge clk); #0.5;
    check(tag, rdata, e);
  endtask

  task automatic set_src(input logic [63:0] v);
    @(posedge clk); #1 src = v;
  endtask

  // every cycle: outputs follow the model's verdict from the previous edge (R9)
  always @(negedge clk) begin
    if (!rst_n) begin
      exp_n = 1'b0; exp_f = 1'b0;
      check("R9 norm out in reset", {31'd0, irq_n}, 32'd0);
    end else begin
      check("R9 norm out", {31'd0, irq_n}, {31'd0, exp_n});
      check("R9 fast out", {31'd0, irq_f}, {31'd0, exp_f});
      exp_n = (m_nvec() != 16'hFFFF);
      exp_f = (m_fvec() != 16'hFFFF);
    end
  end

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  logic [7:0] wr_pick [12] = '{8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18,
                               8'h1C, 8'h20, 8'h2C, 8'h3C, 8'h50, 8'h54};

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset values
    rd_lit("R1 ctrl", 8'h00, 32'h0);
    rd_lit("R1 thr", 8'h04, 32'h1F);
    rd_lit("R1 en low", 8'h14, 32'h0);
    rd_lit("R1 route high", 8'h18, 32'h0);
    rd_lit("R1 prio word0", 8'h3C, 32'h0);
    rd_lit("R1 nvec", 8'h40, 32'hFFFF_0000);
    rd_lit("R1 fvec", 8'h44, 32'hFFFF_0000);

    // R2 split words
    wr(8'h14, 32'hA5A5_0F0F); wr(8'h10, 32'h1234_5678);
    wr(8'h1C, 32'h0000_FFFF); wr(8'h18, 32'h8000_0001);
    wr(8'h54, 32'h0000_0004); wr(8'h50, 32'h0100_0000);
    rd_lit("R2 en low", 8'h14, 32'hA5A5_0F0F);
    rd_lit("R2 en high", 8'h10, 32'h1234_5678);
    rd_lit("R2 route low", 8'h1C, 32'h0000_FFFF);
    rd_lit("R2 route high", 8'h18, 32'h8000_0001);
    rd_lit("R2 force high", 8'h50, 32'h0100_0000);
    rd_chk("R4 normal pending low with force", 8'h5C);
    rd_chk("R4 fast pending low with force", 8'h64);
    wr(8'h14, 0); wr(8'h10, 0); wr(8'h1C, 0); wr(8'h18, 0);
    wr(8'h54, 0); wr(8'h50, 0);

    // R3 by-number enable/disable
    wr(8'h08, 5); wr(8'h08, 40); wr(8'h08, 63); wr(8'h08, 64); wr(8'h08, 32'hFFFF_FFFF);
    rd_lit("R3 en low after set", 8'h14, 32'h0000_0020);
    rd_lit("R3 en high after set", 8'h10, 32'h8000_0100);
    wr(8'h0C, 40); wr(8'h0C, 64);
    rd_lit("R3 en high after clear", 8'h10, 32'h8000_0000);
    rd_lit("R3 number word reads 0", 8'h08, 32'h0);

    // R5 priority layout
    wr(8'h3C, 32'h7654_3210); wr(8'h20, 32'hF000_000A);
    rd_lit("R5 prio word0 at 0x3C", 8'h3C, 32'h7654_3210);
    rd_lit("R5 prio word7 at 0x20", 8'h20, 32'hF000_000A);

    // R6 ranking: line 63 prio F beats line 5 prio 5
    set_src(64'h8000_0000_0000_0020);
    rd_lit("R6 highest prio wins", 8'h40, 32'h003F_0000);
    rd_chk("R4 source high", 8'h48);
    rd_chk("R4 normal pending high", 8'h58);
    set_src(64'h20);
    rd_lit("R6 single line", 8'h40, 32'h0005_0000);
    wr(8'h3C, 32'h3333_3333); wr(8'h08, 2); wr(8'h08, 6);
    set_src(64'h44);
    rd_lit("R6 tie goes to higher line", 8'h40, 32'h0006_0000);
    set_src(64'h0);
    rd_lit("R6 none pending", 8'h40, 32'hFFFF_0000);

    // R7 threshold
    set_src(64'h40);
    wr(8'h04, 3);
    rd_lit("R7 prio equal to threshold masked", 8'h40, 32'hFFFF_0000);
    wr(8'h04, 2);
    rd_lit("R7 prio above threshold passes", 8'h40, 32'h0006_0000);
    wr(8'h04, 32'h13);
    rd_lit("R7 bit4 bypass", 8'h40, 32'h0006_0000);
    wr(8'h04, 0);
    wr(8'h3C, 32'h0);
    rd_lit("R7 prio 0 masked by threshold 0", 8'h40, 32'hFFFF_0000);
    wr(8'h04, 32'h1F);

    // R8 fast routing
    wr(8'h08, 40); wr(8'h18, 32'h8000_0100);
    set_src(64'h8000_0100_0000_0044);
    rd_lit("R8 fast highest line", 8'h44, 32'h003F_0000);
    rd_lit("R8 routed lines leave normal", 8'h40, 32'h0006_0000);
    rd_chk("R4 fast pending high", 8'h60);
    wr(8'h18, 32'h0000_0100);
    rd_lit("R8 fast after reroute", 8'h44, 32'h0028_0000);

    // R10 read-only and unmapped
    wr(8'h48, 32'hFFFF_FFFF); wr(8'h58, 32'hFFFF_FFFF);
    wr(8'h40, 32'h0); wr(8'h60, 32'hFFFF_FFFF);
    rd_chk("R10 source unchanged", 8'h48);
    rd_chk("R10 pending unchanged", 8'h58);
    rd_lit("R10 en high unchanged", 8'h10, 32'h8000_0100);
    rd_lit("R10 unmapped reads 0", 8'h70, 32'h0);
    wr(8'h15, 32'hFFFF_FFFF);
    rd_chk("R10 misaligned write ignored", 8'h14);
    rd_lit("R10 misaligned read 0", 8'h11, 32'h0);

    // random stretch against the model
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom_range(0, 4);
      if (op == 0) set_src({$urandom(), $urandom()});
      else if (op == 1) begin
        logic [7:0] a;
        a = wr_pick[$urandom_range(0, 11)];
        if (a == 8'h08 || a == 8'h0C) wr(a, $urandom_range(0, 70));
        else if (a == 8'h04) wr(a, $urandom_range(0, 31));
        else if (a == 8'h50 || a == 8'h54) wr(a, $urandom() & $urandom() & $urandom());
        else wr(a, $urandom());
      end
      else if (op == 2) rd_chk("R6 random normal vector", 8'h40);
      else if (op == 3) rd_chk("R8 random fast vector", 8'h44);
      else rd_chk("R4 random pending low", 8'h5C);
    end

    repeat (3) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule